// File: doc/BRIEF.md
# Streaming Page Hamming Code Generator

This block sits on a flash data path and watches page data as it streams by, one byte per accepted cycle. For every 512-byte block it builds a 24-bit single-error-correcting Hamming code: twelve parity bits formed from the byte address and bit index of every set data bit, plus twelve more formed from their complements. Software later compares this code with the one stored in the spare area. Correction itself is done elsewhere.

A page opens with a one-cycle start pulse, which also samples the page-size selection and clears every result. Bytes then arrive with a valid strobe. A page ends when the configured number of blocks has been seen, or earlier when a byte carries the end-of-page marker. Each finished block's code lands in its own 32-bit result slot, in block order, with a status byte whose valid bit tells software that the code may be used. A busy flag stays high from the start pulse until the last code is visible.

Top module: `ecc_stream_gen`

## Requirements
- R1: After reset every result slot reads 0 and `busy_o` is low.
- R2: Within a block, byte address a (0..511, restarting per block) and bit index b (0..7) form the 12-bit value {a[8:0], b[2:0]}. Code bits [11:0] are the XOR of that value over every set data bit; code bits [23:12] are the XOR of its bitwise complement over every set data bit.
- R3: A written slot holds the code in bits [23:0] and the status byte 8'h40 in bits [31:24] (bit 30 = valid). A slot that has not been written reads all zero.
- R4: Every 512 accepted bytes close a block; block k of a page is written to slot k (bits [32k+31:32k] of `blk_res_o`), and a written slot keeps its value until the next page start.
- R5: `page_size_i` is sampled at the page start: 2'd1 and 2'd0 select one block, 2'd2 two blocks, 2'd3 four blocks. The page closes by itself after that many blocks.
- R6: A byte accepted with `last_i` high closes the page at once; a partly filled block is written with the valid bit set, and slots after it stay zero.
- R7: `busy_o` rises only in the cycle after a page start, stays high while the page is open, and falls in the same cycle that the final code becomes visible, one cycle after the closing byte is accepted.
- R8: A page start clears all slots and valid bits in the next cycle; a byte presented in the same cycle as the start pulse is not accepted.
- R9: Cycles with `valid_i` low, and any bytes offered while no page is open, change no result and no code (including their `last_i`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| page_start_i | input | 1 | Opens a page, clears results, samples page size |
| page_size_i | input | 2 | Blocks per page selection (see R5) |
| valid_i | input | 1 | Byte on `data_i` is offered this cycle |
| data_i | input | 8 | Page data byte |
| last_i | input | 1 | Offered byte is the final byte of the page |
| blk_res_o | output | 4x32 | Per-block result slots, status byte over 24-bit code |
| busy_o | output | 1 | Page open or final code still being written |

## Verification
Every cycle the assertions check the shape of the result slots (zero or valid status over a code), that a start pulse empties all slots and raises busy, that busy never rises without a start, that results stay frozen while the block is idle, and that a written slot holds until the next page. The numeric code values, the slot each block lands in, page closure by size or by the end marker, and the exact cycle in which busy falls can only be shown by the bench's scenarios, which compare against codes computed bit by bit from the data they sent.

// File: rtl/ecc_gen_pkg.sv
package ecc_gen_pkg;
  localparam int unsigned STAT_W      = 8;
  localparam int unsigned STAT_VLD_B  = 6;
  localparam logic [STAT_W-1:0] STAT_VALID = STAT_W'(1 << STAT_VLD_B);

  // index of the final block for a page-size code
  function automatic int unsigned last_blk_of(input logic [1:0] sz, input int unsigned max_blks);
    int unsigned lb;
    case (sz)
      2'd2:    lb = 1;
      2'd3:    lb = 3;
      default: lb = 0;
    endcase
    if (lb > max_blks - 1) lb = max_blks - 1;
    return lb;
  endfunction
endpackage

// File: rtl/ecc_byte_term.sv
module ecc_byte_term #(
  parameter int unsigned ADDR_W = 9,
  localparam int unsigned HALF_W = ADDR_W + 3
) (
  input  logic [7:0]        byte_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [HALF_W-1:0] term_o,
  output logic              ones_odd_o
);
  logic [2:0] idx_x;

  always_comb begin
    idx_x = '0;
    for (int b = 0; b < 8; b++)
      if (byte_i[b]) idx_x = idx_x ^ 3'(b);
  end

  // address contributes once per set bit: survives only for odd popcount
  assign ones_odd_o = ^byte_i;
  assign term_o     = {(ones_odd_o ? addr_i : '0), idx_x};
endmodule

// File: rtl/ecc_accum.sv
module ecc_accum #(
  parameter int unsigned HALF_W = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                take_i,
  input  logic                seal_i,
  input  logic [HALF_W-1:0]   term_i,
  input  logic                ones_i,
  output logic                fin_vld_o,
  output logic [2*HALF_W-1:0] fin_code_o
);
  logic [HALF_W-1:0] odd_q, odd_nxt;
  logic              par_q, par_nxt;

  assign odd_nxt = odd_q ^ term_i;
  assign par_nxt = par_q ^ ones_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      odd_q      <= '0;
      par_q      <= 1'b0;
      fin_vld_o  <= 1'b0;
      fin_code_o <= '0;
    end else if (clr_i) begin
      odd_q      <= '0;
      par_q      <= 1'b0;
      fin_vld_o  <= 1'b0;
    end else begin
      fin_vld_o <= take_i & seal_i;
      if (take_i) begin
        if (seal_i) begin
          odd_q      <= '0;
          par_q      <= 1'b0;
          // complement set: each set bit adds all-ones, so odd total count flips every bit
          fin_code_o <= {odd_nxt ^ {HALF_W{par_nxt}}, odd_nxt};
        end else begin
          odd_q <= odd_nxt;
          par_q <= par_nxt;
        end
      end
    end
  end
endmodule

// File: rtl/ecc_seq.sv
module ecc_seq
  import ecc_gen_pkg::*;
#(
  parameter int unsigned BLK_BYTES = 512,
  parameter int unsigned MAX_BLKS  = 4,
  localparam int unsigned ADDR_W = $clog2(BLK_BYTES),
  localparam int unsigned BLK_W  = (MAX_BLKS > 1) ? $clog2(MAX_BLKS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              page_start_i,
  input  logic [1:0]        page_size_i,
  input  logic              valid_i,
  input  logic              last_i,
  output logic              take_o,
  output logic              seal_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BLK_W-1:0]  fin_idx_o,
  output logic              active_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [BLK_W-1:0]  blk_q, last_blk_q;
  logic              active_q, blk_full, page_done;

  assign take_o    = active_q & valid_i & ~page_start_i;
  assign blk_full  = (addr_q == ADDR_W'(BLK_BYTES - 1));
  assign seal_o    = take_o & (blk_full | last_i);
  assign page_done = take_o & (last_i | (blk_full & (blk_q == last_blk_q)));
  assign addr_o    = addr_q;
  assign active_o  = active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      addr_q     <= '0;
      blk_q      <= '0;
      last_blk_q <= '0;
      fin_idx_o  <= '0;
    end else if (page_start_i) begin
      active_q   <= 1'b1;
      addr_q     <= '0;
      blk_q      <= '0;
      last_blk_q <= BLK_W'(last_blk_of(page_size_i, MAX_BLKS));
    end else if (take_o) begin
      if (seal_o) begin
        addr_q    <= '0;
        blk_q     <= blk_q + BLK_W'(1);
        fin_idx_o <= blk_q;
      end else begin
        addr_q <= addr_q + ADDR_W'(1);
      end
      if (page_done) active_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ecc_stream_gen.sv
module ecc_stream_gen
  import ecc_gen_pkg::*;
#(
  parameter int unsigned BLK_BYTES = 512,
  parameter int unsigned MAX_BLKS  = 4,
  localparam int unsigned ADDR_W = $clog2(BLK_BYTES),
  localparam int unsigned HALF_W = ADDR_W + 3,
  localparam int unsigned RES_W  = 2 * HALF_W + STAT_W
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             page_start_i,
  input  logic [1:0]                       page_size_i,
  input  logic                             valid_i,
  input  logic [7:0]                       data_i,
  input  logic                             last_i,
  output logic [MAX_BLKS-1:0][RES_W-1:0]   blk_res_o,
  output logic                             busy_o
);
  localparam int unsigned BLK_W = (MAX_BLKS > 1) ? $clog2(MAX_BLKS) : 1;

  logic                take, seal, active, ones_odd, fin_vld;
  logic [ADDR_W-1:0]   addr;
  logic [BLK_W-1:0]    fin_idx;
  logic [HALF_W-1:0]   term;
  logic [2*HALF_W-1:0] fin_code;

  ecc_seq #(.BLK_BYTES(BLK_BYTES), .MAX_BLKS(MAX_BLKS)) u_seq (
    .clk_i, .rst_ni, .page_start_i, .page_size_i, .valid_i, .last_i,
    .take_o(take), .seal_o(seal), .addr_o(addr), .fin_idx_o(fin_idx), .active_o(active)
  );

  ecc_byte_term #(.ADDR_W(ADDR_W)) u_term (
    .byte_i(data_i), .addr_i(addr), .term_o(term), .ones_odd_o(ones_odd)
  );

  ecc_accum #(.HALF_W(HALF_W)) u_acc (
    .clk_i, .rst_ni, .clr_i(page_start_i), .take_i(take), .seal_i(seal),
    .term_i(term), .ones_i(ones_odd), .fin_vld_o(fin_vld), .fin_code_o(fin_code)
  );

  for (genvar g = 0; g < MAX_BLKS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        blk_res_o[g] <= '0;
      else if (page_start_i)
        blk_res_o[g] <= '0;
      else if (fin_vld && (fin_idx == BLK_W'(g)))
        blk_res_o[g] <= {STAT_VALID, fin_code};
    end
  end

  assign busy_o = active | fin_vld;
endmodule

// File: rtl/ecc_stream_gen_chk.sv
module ecc_stream_gen_chk #(
  parameter int unsigned MAX_BLKS = 4,
  parameter int unsigned RES_W    = 32
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           page_start_i,
  input logic [MAX_BLKS-1:0][RES_W-1:0] blk_res_o,
  input logic                           busy_o
);
  function automatic logic slots_ok(input logic [MAX_BLKS-1:0][RES_W-1:0] r);
    for (int i = 0; i < MAX_BLKS; i++)
      if (r[i][RES_W-1 -: 8] != 8'h40 && r[i] != '0) return 1'b0;
    return 1'b1;
  endfunction

  // R3
  slot_form_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slots_ok(blk_res_o));

  // R8
  page_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_start_i |=> (busy_o && blk_res_o == '0));

  // R7
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(page_start_i));

  // R9
  idle_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !page_start_i) |=> $stable(blk_res_o));

  for (genvar g = 0; g < MAX_BLKS; g++) begin : g_hold
    // R4
    slot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (blk_res_o[g][RES_W-2] && !page_start_i) |=> $stable(blk_res_o[g]));
  end
endmodule

bind ecc_stream_gen ecc_stream_gen_chk #(.MAX_BLKS(MAX_BLKS), .RES_W(RES_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .page_start_i(page_start_i),
  .blk_res_o(blk_res_o), .busy_o(busy_o)
);

// File: tb/ecc_stream_gen_test.sv
module ecc_stream_gen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic page_start = 1'b0;
  logic [1:0] page_size = 2'd0;
  logic valid = 1'b0;
  logic [7:0] data = 8'h00;
  logic last = 1'b0;
  logic [3:0][31:0] res;
  logic busy;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  logic [7:0] mem [2048];

  always #2.5 clk = ~clk;

  ecc_stream_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .page_start_i(page_start), .page_size_i(page_size),
    .valid_i(valid), .data_i(data), .last_i(last), .blk_res_o(res), .busy_o(busy)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_code(input int base, input int cnt);
    logic [11:0] odd = '0, ev = '0, v;
    for (int a = 0; a < cnt; a++)
      for (int b = 0; b < 8; b++)
        if (mem[base + a][b]) begin
          v = {a[8:0], b[2:0]};
          odd ^= v;
          ev  ^= ~v;
        end
    return {ev, odd};
  endfunction

  function automatic logic [31:0] exp_slot(input int i, input int cap, input int nbytes);
    int total, start, cnt;
    total = (nbytes < cap * 512) ? nbytes : cap * 512;
    start = i * 512;
    if (i >= cap || start >= total) return 32'h0;
    cnt = total - start;
    if (cnt > 512) cnt = 512;
    return {8'h40, exp_code(start, cnt)};
  endfunction

  task automatic fill(input int kind, input int seed);
    for (int k = 0; k < 2048; k++)
      case (kind)
        0: mem[k] = 8'h00;
        1: mem[k] = 8'hFF;
        default: mem[k] = 8'((k * 37 + seed) ^ (k >> 3) ^ (k * k));
      endcase
  endtask

  task automatic check_slots(input int cap, input int nbytes, input string req);
    for (int i = 0; i < 4; i++)
      chk(res[i] === exp_slot(i, cap, nbytes), req, res[i], exp_slot(i, cap, nbytes));
  endtask

  // opens a page, streams bytes, checks busy timing (R7) and clearing (R8)
  task automatic run_page(input logic [1:0] sz, input int nbytes, input bit use_last, input bit gaps);
    @(negedge clk);
    page_start = 1'b1; page_size = sz;
    @(negedge clk);
    page_start = 1'b0;
    chk(busy === 1'b1, "R7 busy after start", 32'(busy), 32'd1);
    chk(res === '0, "R8 slots cleared", res[0], 32'h0);
    for (int k = 0; k < nbytes; k++) begin
      if (gaps && (k % 3 == 1)) begin
        valid = 1'b0; data = 8'hA5; last = 1'b1;
        @(negedge clk);
      end
      valid = 1'b1; data = mem[k]; last = use_last && (k == nbytes - 1);
      @(negedge clk);
    end
    valid = 1'b0; last = 1'b0;
    chk(busy === 1'b1, "R7 busy after final byte", 32'(busy), 32'd1);
    @(negedge clk);
    chk(busy === 1'b0, "R7 busy falls", 32'(busy), 32'd0);
  endtask

  task automatic t_reset;
    chk(busy === 1'b0, "R1 busy", 32'(busy), 32'd0);
    for (int i = 0; i < 4; i++) chk(res[i] === 32'h0, "R1 slot", res[i], 32'h0);
  endtask

  task automatic t_single_bit;
    fill(0, 0);
    mem[5] = 8'h08;
    run_page(2'd1, 512, 1'b0, 1'b0);
    chk(res[0] === 32'h40FD402B, "R2 R3 single bit", res[0], 32'h40FD402B);
    chk(res[1] === 32'h0, "R5 one block", res[1], 32'h0);
  endtask

  task automatic t_all_ones;
    fill(1, 0);
    run_page(2'd2, 1024, 1'b0, 1'b0);
    chk(res[0] === 32'h40000000, "R2 all ones", res[0], 32'h40000000);
    chk(res[1] === 32'h40000000, "R4 second block", res[1], 32'h40000000);
    chk(res[2] === 32'h0, "R5 two blocks", res[2], 32'h0);
  endtask

  task automatic t_full_page;
    fill(2, 11);
    run_page(2'd3, 2048, 1'b0, 1'b0);
    check_slots(4, 2048, "R4 R5 four blocks");
  endtask

  task automatic t_overrun;
    logic [3:0][31:0] snap;
    fill(2, 99);
    run_page(2'd2, 1024, 1'b0, 1'b0);
    check_slots(2, 1024, "R5 two blocks data");
    snap = res;
    for (int k = 0; k < 20; k++) begin
      valid = 1'b1; data = 8'(k * 13 + 1); last = (k == 19);
      @(negedge clk);
      chk(busy === 1'b0, "R9 closed page busy", 32'(busy), 32'd0);
    end
    valid = 1'b0; last = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 4; i++) chk(res[i] === snap[i], "R9 closed page ignored", res[i], snap[i]);
  endtask

  task automatic t_early_last;
    fill(2, 5);
    run_page(2'd3, 700, 1'b1, 1'b0);
    check_slots(4, 700, "R6 early last");
  endtask

  task automatic t_size_zero;
    fill(2, 77);
    run_page(2'd0, 512, 1'b0, 1'b0);
    check_slots(1, 512, "R5 size code zero");
  endtask

  task automatic t_gaps;
    fill(2, 31);
    run_page(2'd2, 900, 1'b1, 1'b1);
    check_slots(2, 900, "R9 valid gaps");
  endtask

  task automatic t_start_collide;
    @(negedge clk);
    page_start = 1'b1; page_size = 2'd3; valid = 1'b1; data = 8'hFF; last = 1'b1;
    @(negedge clk);
    page_start = 1'b0; valid = 1'b1; data = 8'h01; last = 1'b1;
    chk(res === '0, "R8 clear", res[0], 32'h0);
    @(negedge clk);
    valid = 1'b0; last = 1'b0;
    @(negedge clk);
    chk(res[0] === 32'h40FFF000, "R8 start byte ignored", res[0], 32'h40FFF000);
    chk(res[1] === 32'h0, "R6 later slot empty", res[1], 32'h0);
    chk(busy === 1'b0, "R7 idle", 32'(busy), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_bit();
    t_all_ones();
    t_full_page();
    t_overrun();
    t_early_last();
    t_size_zero();
    t_gaps();
    t_start_collide();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule